// File: doc/BRIEF.md
# Way-Location Predicting Cache Controller

This block controls a 4-way set-associative second-level cache with 64 sets. Beside the cache sits a small direct-mapped location table, indexed by the virtual address, that records which way held a line the last time it was found. The table is read in the same cycle as the request, so its lookup runs in parallel with address translation.

When the table hits, only the recorded way is enabled, so the access costs as much as a direct-mapped probe and answers one cycle later. When the table misses, all four ways are enabled together, as in a normal set-associative probe. The answer follows two cycles later, and the resolved way is written into the table. If the recorded way no longer holds the line, because the same virtual address now maps to another physical line, the entry is dropped and all ways are probed in the next cycle. The answer still arrives two cycles after the request, so no access takes longer than an ordinary all-way probe.

A fill port places lines in the behavioural tag and data arrays. An invalidate port evicts a line by physical address. Both ports remove any table entry that points at the affected set and way.

Top module: `wloc_cache_ctrl`

## Requirements
- R1: Out of reset, resp_valid is 0, req_ready is 1, and every location table entry is invalid, so the first access to any address uses an all-way probe.
- R2: A request that misses in the location table drives way_en to 4'b1111 in the request cycle. It produces resp_valid exactly two cycles after the request cycle.
- R3: A request that hits in the location table drives way_en one-hot on the recorded way in the request cycle. It produces resp_valid one cycle after the request cycle, provided the recorded way still matches.
- R4: A response to a cache hit carries resp_hit=1 and the data word held in the matching way. Physical address bits [5:0] select the set and bits [15:6] form the tag.
- R5: A request whose line is in no way returns resp_hit=0 with resp_data=0 and writes no table entry, so the next access with the same addresses again probes all ways.
- R6: When the recorded way does not hold the requested line, way_en is one-hot in the request cycle and 4'b1111 in the next cycle. The response comes two cycles after the request with the correct result, and the table entry is rewritten with the resolved way.
- R7: req_ready is 0 in every cycle in which a multi-cycle access is outstanding. Requests are accepted only while req_ready is 1.
- R8: An invalidate with a physical line address clears that line in the cache, together with any location table entry pointing to it. A later access to that line probes all ways and misses.
- R9: A fill into a set and way clears any location table entry that points to that set and way.
- R10: The location table is direct-mapped. Virtual address bits [3:0] pick the entry and bits [15:4] are the stored virtual tag, so two addresses sharing bits [3:0] displace each other.
- R11: way_en is 0 in every cycle without an accepted request or a pending retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Controller can accept a request |
| req_va | input | 16 | Virtual line address, indexes the location table |
| req_pa | input | 16 | Physical line address, indexes the cache |
| way_en | output | 4 | Per-way array enable in this cycle |
| resp_valid | output | 1 | Response strobe |
| resp_hit | output | 1 | Line found in the cache |
| resp_data | output | 32 | Data word of the found line, 0 on a miss |
| fill_valid | input | 1 | Write a line into the arrays |
| fill_way | input | 2 | Way to write |
| fill_pa | input | 16 | Physical line address of the filled line |
| fill_data | input | 32 | Data word of the filled line |
| inv_valid | input | 1 | Evict a line |
| inv_pa | input | 16 | Physical line address to evict |

## Verification
The hardest case to reach is the stale prediction, because the fill and invalidate ports keep the location table consistent with every change the cache can see. The bench reaches it by remapping a virtual address. The virtual address is first trained against one physical line. It is then presented with a physical address in a different set whose line sits in a different way. The bench then checks the one-hot probe, the all-way retry in the next cycle, the two-cycle answer, and the corrected single-way probe that follows.

// File: rtl/wloc_cache_ctrl.sv
module wloc_cache_ctrl #(
  parameter int VA_W   = 16,
  parameter int PA_W   = 16,
  parameter int DATA_W = 32,
  parameter int WAYS   = 4,
  parameter int SETS   = 64,
  parameter int LT_N   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [VA_W-1:0]            req_va,
  input  logic [PA_W-1:0]            req_pa,
  output logic [WAYS-1:0]            way_en,
  output logic                       resp_valid,
  output logic                       resp_hit,
  output logic [DATA_W-1:0]          resp_data,
  input  logic                       fill_valid,
  input  logic [$clog2(WAYS)-1:0]    fill_way,
  input  logic [PA_W-1:0]            fill_pa,
  input  logic [DATA_W-1:0]          fill_data,
  input  logic                       inv_valid,
  input  logic [PA_W-1:0]            inv_pa
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = PA_W - SET_W;
  localparam int LT_W  = $clog2(LT_N);
  localparam int VT_W  = VA_W - LT_W;

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_RETRY} st_t;
  st_t st;

  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [DATA_W-1:0] data_q [SETS][WAYS];
  logic [WAYS-1:0]   tv_q   [SETS];

  logic              lt_v    [LT_N];
  logic [VT_W-1:0]   lt_vtag [LT_N];
  logic [WAY_W-1:0]  lt_way  [LT_N];
  logic [SET_W-1:0]  lt_set  [LT_N];

  logic [PA_W-1:0]   hold_pa;
  logic [VA_W-1:0]   hold_va;
  logic              hold_hit;
  logic [DATA_W-1:0] hold_data;

  logic [PA_W-1:0]   probe_pa;
  logic [VA_W-1:0]   probe_va;
  logic [SET_W-1:0]  p_set;
  logic [TAG_W-1:0]  p_tag;
  logic [WAYS-1:0]   match, inv_match;
  logic              full_hit, inv_hit;
  logic [WAY_W-1:0]  full_way, inv_way;
  logic [DATA_W-1:0] full_data;
  logic [LT_W-1:0]   lt_idx;
  logic              lt_hit, single_hit, accept;

  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign probe_pa  = (st == S_RETRY) ? hold_pa : req_pa;
  assign probe_va  = (st == S_RETRY) ? hold_va : req_va;
  assign p_set     = probe_pa[SET_W-1:0];
  assign p_tag     = probe_pa[PA_W-1:SET_W];
  assign lt_idx    = req_va[LT_W-1:0];
  assign lt_hit    = lt_v[lt_idx] && (lt_vtag[lt_idx] == req_va[VA_W-1:LT_W]);
  assign single_hit = match[lt_way[lt_idx]];
  assign full_hit  = |match;
  assign full_data = full_hit ? data_q[p_set][full_way] : '0;
  assign inv_hit   = |inv_match;

  always_comb begin
    full_way = '0;
    inv_way  = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      match[w]     = tv_q[p_set][w] && (tag_q[p_set][w] == p_tag);
      inv_match[w] = tv_q[inv_pa[SET_W-1:0]][w] && (tag_q[inv_pa[SET_W-1:0]][w] == inv_pa[PA_W-1:SET_W]);
      if (match[w])     full_way = WAY_W'(w);
      if (inv_match[w]) inv_way  = WAY_W'(w);
    end
  end

  always_comb begin
    way_en = '0;
    if (st == S_RETRY)  way_en = '1;
    else if (accept)    way_en = lt_hit ? (WAYS'(1) << lt_way[lt_idx]) : '1;
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      tag_q[fill_pa[SET_W-1:0]][fill_way]  <= fill_pa[PA_W-1:SET_W];
      data_q[fill_pa[SET_W-1:0]][fill_way] <= fill_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_data  <= '0;
      hold_pa    <= '0;
      hold_va    <= '0;
      hold_hit   <= 1'b0;
      hold_data  <= '0;
      for (int s = 0; s < SETS; s++) tv_q[s] <= '0;
      for (int i = 0; i < LT_N; i++) begin
        lt_v[i]    <= 1'b0;
        lt_vtag[i] <= '0;
        lt_way[i]  <= '0;
        lt_set[i]  <= '0;
      end
    end else begin
      resp_valid <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (lt_hit && single_hit) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_data  <= data_q[p_set][lt_way[lt_idx]];
          end else if (lt_hit) begin
            lt_v[lt_idx] <= 1'b0;
            hold_pa      <= req_pa;
            hold_va      <= req_va;
            st           <= S_RETRY;
          end else begin
            hold_hit  <= full_hit;
            hold_data <= full_data;
            st        <= S_HOLD;
          end
        end
        S_HOLD: begin
          resp_valid <= 1'b1;
          resp_hit   <= hold_hit;
          resp_data  <= hold_data;
          st         <= S_IDLE;
        end
        default: begin
          resp_valid <= 1'b1;
          resp_hit   <= full_hit;
          resp_data  <= full_data;
          st         <= S_IDLE;
        end
      endcase
      if (full_hit && (st == S_RETRY || (accept && !lt_hit))) begin
        lt_v[probe_va[LT_W-1:0]]    <= 1'b1;
        lt_vtag[probe_va[LT_W-1:0]] <= probe_va[VA_W-1:LT_W];
        lt_way[probe_va[LT_W-1:0]]  <= full_way;
        lt_set[probe_va[LT_W-1:0]]  <= p_set;
      end
      if (fill_valid) tv_q[fill_pa[SET_W-1:0]][fill_way] <= 1'b1;
      if (inv_valid && inv_hit) tv_q[inv_pa[SET_W-1:0]][inv_way] <= 1'b0;
      for (int i = 0; i < LT_N; i++) begin
        if (fill_valid && lt_set[i] == fill_pa[SET_W-1:0] && lt_way[i] == fill_way)
          lt_v[i] <= 1'b0;
        if (inv_valid && inv_hit && lt_set[i] == inv_pa[SET_W-1:0] && lt_way[i] == inv_way)
          lt_v[i] <= 1'b0;
      end
    end
  end

  // R2
  full_probe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (&way_en)) |=> (!resp_valid && !req_ready) ##1 resp_valid);

  // R3
  single_probe_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && $onehot(way_en)) |=> (resp_valid || !req_ready));

  // R6
  retry_all_ways_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && $onehot(way_en)) |=> (resp_valid || (&way_en)));

  // R11
  way_en_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(way_en) || (&way_en)));

  // R11
  idle_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |-> (way_en == '0));
endmodule

// File: tb/wloc_cache_ctrl_tb.sv
module wloc_cache_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_va = '0;
  logic [15:0] req_pa = '0;
  logic [3:0]  way_en;
  logic        resp_valid, resp_hit;
  logic [31:0] resp_data;
  logic        fill_valid = 1'b0;
  logic [1:0]  fill_way = '0;
  logic [15:0] fill_pa = '0;
  logic [31:0] fill_data = '0;
  logic        inv_valid = 1'b0;
  logic [15:0] inv_pa = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wloc_cache_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_pa(req_pa), .way_en(way_en), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .resp_data(resp_data), .fill_valid(fill_valid),
    .fill_way(fill_way), .fill_pa(fill_pa), .fill_data(fill_data),
    .inv_valid(inv_valid), .inv_pa(inv_pa)
  );

  function automatic logic [15:0] pa_of(input logic [9:0] tag, input logic [5:0] set);
    return {tag, set};
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [1:0] w, input logic [15:0] pa, input logic [31:0] d);
    @(negedge clk);
    fill_valid = 1'b1; fill_way = w; fill_pa = pa; fill_data = d;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic evict(input logic [15:0] pa);
    @(negedge clk);
    inv_valid = 1'b1; inv_pa = pa;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic access(input logic [15:0] va, input logic [15:0] pa,
                        output logic [3:0] en0, output logic [3:0] en1,
                        output logic rdy1, output int lat,
                        output logic hit, output logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_pa = pa;
    #1 en0 = way_en;
    @(negedge clk);
    req_valid = 1'b0;
    #1 en1 = way_en;
    rdy1 = req_ready;
    lat = 1;
    while (!resp_valid && lat < 6) begin
      @(negedge clk);
      lat++;
    end
    hit = resp_hit;
    data = resp_data;
    @(negedge clk);
  endtask

  logic [3:0]  e0, e1;
  logic        r1, h;
  int          lt;
  logic [31:0] d;

  task automatic t_reset;
    @(negedge clk);
    check(resp_valid == 1'b0, "R1 resp_valid", 32'(resp_valid), 0);
    check(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 1);
    check(way_en == 4'b0, "R11 idle way_en", 32'(way_en), 0);
  endtask

  task automatic t_first_access;
    fill(2'd2, pa_of(10'h012, 6'd5), 32'hAAAA_0001);
    access(16'h1003, pa_of(10'h012, 6'd5), e0, e1, r1, h, d, lt);
  endtask

  task automatic run_req(input logic [15:0] va, input logic [15:0] pa);
    access(va, pa, e0, e1, r1, lt, h, d);
  endtask

  task automatic t_full_then_single;
    fill(2'd2, pa_of(10'h012, 6'd5), 32'hAAAA_0001);
    run_req(16'h1003, pa_of(10'h012, 6'd5));
    check(e0 == 4'b1111, "R1 R2 first access all ways", 32'(e0), 32'hF);
    check(lt == 2, "R2 full probe latency", 32'(lt), 2);
    check(r1 == 1'b0, "R7 ready low while outstanding", 32'(r1), 0);
    check(h == 1'b1 && d == 32'hAAAA_0001, "R4 hit data", d, 32'hAAAA_0001);
    run_req(16'h1003, pa_of(10'h012, 6'd5));
    check(e0 == 4'b0100, "R3 single way enable", 32'(e0), 32'h4);
    check(lt == 1, "R3 single probe latency", 32'(lt), 1);
    check(h == 1'b1 && d == 32'hAAAA_0001, "R4 hit data via table", d, 32'hAAAA_0001);
  endtask

  task automatic t_cache_miss;
    run_req(16'h0047, pa_of(10'h055, 6'd5));
    check(e0 == 4'b1111 && lt == 2, "R5 miss uses full probe", 32'(lt), 2);
    check(h == 1'b0 && d == 32'h0, "R5 miss flag and zero data", {31'h0, h} | d, 0);
    run_req(16'h0047, pa_of(10'h055, 6'd5));
    check(e0 == 4'b1111, "R5 no entry written on miss", 32'(e0), 32'hF);
  endtask

  task automatic t_stale;
    fill(2'd1, pa_of(10'h033, 6'd9), 32'hBBBB_0002);
    run_req(16'h1003, pa_of(10'h033, 6'd9));
    check(e0 == 4'b0100, "R6 stale probe starts single way", 32'(e0), 32'h4);
    check(e1 == 4'b1111, "R6 retry probes all ways", 32'(e1), 32'hF);
    check(r1 == 1'b0, "R7 ready low during retry", 32'(r1), 0);
    check(lt == 2, "R6 retry latency", 32'(lt), 2);
    check(h == 1'b1 && d == 32'hBBBB_0002, "R6 retry result", d, 32'hBBBB_0002);
    run_req(16'h1003, pa_of(10'h033, 6'd9));
    check(e0 == 4'b0010 && lt == 1, "R6 entry rewritten", 32'(e0), 32'h2);
  endtask

  task automatic t_conflict;
    run_req(16'h2003, pa_of(10'h012, 6'd5));
    check(e0 == 4'b1111 && h == 1'b1, "R10 other vtag misses table", 32'(e0), 32'hF);
    run_req(16'h1003, pa_of(10'h033, 6'd9));
    check(e0 == 4'b1111, "R10 conflicting entry displaced", 32'(e0), 32'hF);
  endtask

  task automatic t_evict;
    evict(pa_of(10'h033, 6'd9));
    run_req(16'h1003, pa_of(10'h033, 6'd9));
    check(e0 == 4'b1111, "R8 entry cleared by invalidate", 32'(e0), 32'hF);
    check(h == 1'b0, "R8 line gone after invalidate", 32'(h), 0);
  endtask

  task automatic t_fill_clears;
    run_req(16'h2005, pa_of(10'h012, 6'd5));
    run_req(16'h2005, pa_of(10'h012, 6'd5));
    check(e0 == 4'b0100, "R9 entry trained", 32'(e0), 32'h4);
    fill(2'd2, pa_of(10'h077, 6'd5), 32'hCCCC_0003);
    run_req(16'h2005, pa_of(10'h012, 6'd5));
    check(e0 == 4'b1111 && h == 1'b0, "R9 fill cleared entry", 32'(e0), 32'hF);
    run_req(16'h4006, pa_of(10'h077, 6'd5));
    check(h == 1'b1 && d == 32'hCCCC_0003, "R4 R9 new line data", d, 32'hCCCC_0003);
    #1 check(way_en == 4'b0, "R11 way_en idle after access", 32'(way_en), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_full_then_single();
    t_cache_miss();
    t_stale();
    t_conflict();
    t_evict();
    t_fill_clears();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule